// File: doc/BRIEF.md
# Dual-Channel PCM Frame Port

This block is the digital serial port of a two-channel voice codec on a time-division multiplexed bus. One bit clock drives it. One frame sync pulse per frame marks where the frame starts. For each frame the port shifts out two 8-bit transmit words as one 16-bit burst. It also collects two 8-bit receive words from the serial input and hands each one out in parallel with a single-cycle strobe. The width of the frame sync pulse selects which channel takes the first slot.

The port also watches the frame sync input. It measures the spacing between frame starts to decide which of the two supported bit-clock rates is in use. If frame sync stays quiet for long enough, it raises a powerdown flag that covers both channels. Frame sync is taken as synchronous to the bit clock. Reset is asynchronous and active low, and its release is synchronised inside the block.

Top module: `pcm_tdm_port`

## Requirements
- R1: A frame sync rising edge sampled at clock edge k starts a frame. `tx_en` is high for exactly 16 cycles, from clock edge k+1 to clock edge k+17.
- R2: If frame sync is sampled low again at edge k+1 (a pulse one cycle wide), the first 8 bits carry channel 0 and the next 8 bits carry channel 1.
- R3: If frame sync is still sampled high at edge k+1 (a pulse two or more cycles wide), the first 8 bits carry channel 1 and the next 8 bits carry channel 0.
- R4: Each transmit word is captured at edge k+1 and sent most significant bit first. `tx_data` is 0 whenever `tx_en` is low.
- R5: `rx_data` is sampled on falling clock edges during the 16 active bit times, most significant bit first, with the slot order of R2 and R3. One rising edge after a word's eighth bit, the word appears on `rx_word0` or `rx_word1`, and the matching valid signal is high for that one cycle.
- R6: A spacing of 256 cycles between consecutive frame sync rising edges sets `rate_ok`=1 and `rate_hi`=0. A spacing of 512 sets `rate_ok`=1 and `rate_hi`=1. Any other spacing leaves the rate unresolved (`rate_ok`=0). Once the rate is resolved, it holds until reset.
- R7: `pwr_down` rises after frame sync has been sampled low on 1024 consecutive edges when `rate_hi`=0, or on 2048 consecutive edges when `rate_hi`=1. One sample fewer leaves it low.
- R8: The next frame sync rising edge clears `pwr_down`, and that frame is transferred normally.
- R9: During and right after reset, `tx_en`, `tx_data`, both valid strobes, `rate_ok`, `rate_hi` and `pwr_down` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | Frame sync pulse, synchronous to clk |
| tx_word0 | input | 8 | Channel 0 transmit word |
| tx_word1 | input | 8 | Channel 1 transmit word |
| tx_data | output | 1 | Serial transmit data |
| tx_en | output | 1 | High during the 16 active transmit bit times (drives the pad enable) |
| rx_data | input | 1 | Serial receive data, sampled on falling edges |
| rx_word0 | output | 8 | Last received channel 0 word |
| rx_vld0 | output | 1 | One-cycle strobe for a new `rx_word0` |
| rx_word1 | output | 8 | Last received channel 1 word |
| rx_vld1 | output | 1 | One-cycle strobe for a new `rx_word1` |
| rate_ok | output | 1 | The bit-clock rate has been resolved |
| rate_hi | output | 1 | The resolved rate is the higher one (512-cycle frames) |
| pwr_down | output | 1 | Both channels are powered down |

## Verification
Frames are run with one-cycle and with wider frame sync pulses, using distinct words on each channel, so a swapped slot order or a reversed bit order shows up as wrong bits. Frame spacings of 256, 512 and 300 cycles separate the two resolved rates from the unresolved case. A 512-cycle frame sent after the low rate has locked shows that the rate does not change. The quiet period is stopped one sample short of each timeout and then one sample later, at both rates, which pins down the exact powerdown threshold. A frame sent after powerdown shows that the flag clears and that data still flows.

// File: rtl/pcm_tdm_pkg.sv
package pcm_tdm_pkg;
  localparam int PCM_WORD_W   = 8;
  localparam int PCM_NUM_CH   = 2;
  localparam int PCM_LO_FRAME = 256;
endpackage

// File: rtl/pcm_frame_ctl.sv
module pcm_frame_ctl #(
  parameter int WORD_W = 8
) (
  input  logic                            clk,
  input  logic                            rst_i,
  input  logic                            fsync,
  input  logic [WORD_W-1:0]               tx_w0,
  input  logic [WORD_W-1:0]               tx_w1,
  output logic                            rise,
  output logic                            active,
  output logic [$clog2(2*WORD_W)-1:0]     bit_cnt,
  output logic                            ch1_first,
  output logic                            tx_data,
  output logic                            tx_en
);
  localparam int FRAME_BITS = 2 * WORD_W;
  localparam int CNT_W      = $clog2(FRAME_BITS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_BITS - 1);

  logic                  fs_prev_q, armed_q, active_q, order_q;
  logic                  armed_n, active_n, order_n;
  logic [CNT_W-1:0]      cnt_q, cnt_n;
  logic [FRAME_BITS-1:0] sh_q, sh_n;

  assign rise = fsync & ~fs_prev_q;

  always_comb begin
    armed_n  = rise;
    active_n = active_q;
    order_n  = order_q;
    cnt_n    = cnt_q;
    sh_n     = sh_q;
    if (armed_q) begin
      active_n = 1'b1;
      cnt_n    = '0;
      order_n  = fsync;
      sh_n     = fsync ? {tx_w1, tx_w0} : {tx_w0, tx_w1};
    end else if (active_q) begin
      sh_n  = {sh_q[FRAME_BITS-2:0], 1'b0};
      cnt_n = cnt_q + 1'b1;
      if (cnt_q == LAST) active_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      fs_prev_q <= 1'b0;
      armed_q   <= 1'b0;
      active_q  <= 1'b0;
      order_q   <= 1'b0;
      cnt_q     <= '0;
      sh_q      <= '0;
    end else begin
      fs_prev_q <= fsync;
      armed_q   <= armed_n;
      active_q  <= active_n;
      order_q   <= order_n;
      cnt_q     <= cnt_n;
      sh_q      <= sh_n;
    end
  end

  assign active    = active_q;
  assign bit_cnt   = cnt_q;
  assign ch1_first = order_q;
  assign tx_en     = active_q;
  assign tx_data   = active_q & sh_q[FRAME_BITS-1];

  // R1: a burst ends only after its last bit slot
  p_tx_len_r1: assert property (@(posedge clk) disable iff (!rst_i)
    $fell(active_q) |-> ($past(cnt_q) == LAST));
  // R2/R3: slot order does not change inside a burst
  p_order_hold_r2: assert property (@(posedge clk) disable iff (!rst_i)
    (active_q && $past(active_q) && !$past(armed_q)) |-> $stable(order_q));
endmodule

// File: rtl/pcm_rx_deser.sv
module pcm_rx_deser #(
  parameter int WORD_W = 8,
  parameter int NCH    = 2
) (
  input  logic                            clk,
  input  logic                            rst_i,
  input  logic                            rx_data,
  input  logic                            active,
  input  logic [$clog2(2*WORD_W)-1:0]     bit_cnt,
  input  logic                            ch1_first,
  output logic [NCH-1:0][WORD_W-1:0]      words,
  output logic [NCH-1:0]                  vld
);
  localparam int CNT_W = $clog2(2 * WORD_W);
  localparam logic [CNT_W-2:0] WLAST = (CNT_W-1)'(WORD_W - 1);

  logic              rx_s_q;
  logic [WORD_W-2:0] sh_q, sh_n;
  logic              word_done;
  logic              slot_ch;
  logic [WORD_W-1:0] full_word;

  always_ff @(negedge clk or negedge rst_i) begin
    if (!rst_i) rx_s_q <= 1'b0;
    else        rx_s_q <= rx_data;
  end

  always_comb begin
    sh_n = sh_q;
    if (active) sh_n = {sh_q[WORD_W-3:0], rx_s_q};
  end

  assign word_done = active && (bit_cnt[CNT_W-2:0] == WLAST);
  assign slot_ch   = bit_cnt[CNT_W-1] ^ ch1_first;
  assign full_word = {sh_q, rx_s_q};

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) sh_q <= '0;
    else        sh_q <= sh_n;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic              hit;
    logic [WORD_W-1:0] w_q, w_n;
    logic              v_q;
    assign hit = word_done && (slot_ch == c[0]);
    always_comb begin
      w_n = w_q;
      if (hit) w_n = full_word;
    end
    always_ff @(posedge clk or negedge rst_i) begin
      if (!rst_i) begin
        w_q <= '0;
        v_q <= 1'b0;
      end else begin
        w_q <= w_n;
        v_q <= hit;
      end
    end
    assign words[c] = w_q;
    assign vld[c]   = v_q;
  end

  // R5: strobes never overlap and only follow an active bit slot
  p_vld_onehot_r5: assert property (@(posedge clk) disable iff (!rst_i)
    $onehot0(vld));
  p_vld_in_frame_r5: assert property (@(posedge clk) disable iff (!rst_i)
    (|vld) |-> $past(active));
endmodule

// File: rtl/pcm_rate_pd.sv
module pcm_rate_pd #(
  parameter int LO_FRAME = 256
) (
  input  logic clk,
  input  logic rst_i,
  input  logic fsync,
  input  logic rise,
  output logic rate_ok,
  output logic rate_hi,
  output logic pwr_down
);
  localparam int HI_FRAME = 2 * LO_FRAME;
  localparam int PD_LO    = 4 * LO_FRAME;
  localparam int PD_HI    = 2 * PD_LO;
  localparam int PER_W    = $clog2(HI_FRAME) + 1;
  localparam int IDLE_W   = $clog2(PD_HI) + 1;

  logic [PER_W-1:0]  per_q, per_n;
  logic [IDLE_W-1:0] idle_q, idle_n, limit;
  logic              seen_q, seen_n, ok_q, ok_n, hi_q, hi_n, pd_q, pd_n;

  assign limit = hi_q ? IDLE_W'(PD_HI) : IDLE_W'(PD_LO);

  always_comb begin
    per_n  = per_q;
    seen_n = seen_q;
    ok_n   = ok_q;
    hi_n   = hi_q;
    if (rise) begin
      seen_n = 1'b1;
      per_n  = PER_W'(1);
      if (seen_q && !ok_q) begin
        if (per_q == PER_W'(LO_FRAME)) begin
          ok_n = 1'b1;
          hi_n = 1'b0;
        end else if (per_q == PER_W'(HI_FRAME)) begin
          ok_n = 1'b1;
          hi_n = 1'b1;
        end
      end
    end else if (per_q != '1) begin
      per_n = per_q + 1'b1;
    end
  end

  always_comb begin
    idle_n = idle_q;
    pd_n   = pd_q;
    if (fsync) idle_n = '0;
    else if (idle_q != IDLE_W'(PD_HI)) idle_n = idle_q + 1'b1;
    if (rise) pd_n = 1'b0;
    else if (!fsync && (idle_n >= limit)) pd_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      per_q  <= '0;
      seen_q <= 1'b0;
      ok_q   <= 1'b0;
      hi_q   <= 1'b0;
      idle_q <= '0;
      pd_q   <= 1'b0;
    end else begin
      per_q  <= per_n;
      seen_q <= seen_n;
      ok_q   <= ok_n;
      hi_q   <= hi_n;
      idle_q <= idle_n;
      pd_q   <= pd_n;
    end
  end

  assign rate_ok  = ok_q;
  assign rate_hi  = hi_q;
  assign pwr_down = pd_q;

  // R6: a resolved rate stays fixed
  p_rate_lock_r6: assert property (@(posedge clk) disable iff (!rst_i)
    rate_ok |=> (rate_ok && $stable(rate_hi)));
  // R7: powerdown only rises while frame sync is quiet
  p_pd_quiet_r7: assert property (@(posedge clk) disable iff (!rst_i)
    $rose(pwr_down) |-> !$past(fsync));
  // R8: a frame sync while powered down wakes the port
  p_pd_clear_r8: assert property (@(posedge clk) disable iff (!rst_i)
    (pwr_down && fsync) |=> !pwr_down);
endmodule

// File: rtl/pcm_tdm_port.sv
module pcm_tdm_port
  import pcm_tdm_pkg::*;
#(
  parameter int WORD_W   = PCM_WORD_W,
  parameter int LO_FRAME = PCM_LO_FRAME
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fsync,
  input  logic [WORD_W-1:0] tx_word0,
  input  logic [WORD_W-1:0] tx_word1,
  output logic              tx_data,
  output logic              tx_en,
  input  logic              rx_data,
  output logic [WORD_W-1:0] rx_word0,
  output logic              rx_vld0,
  output logic [WORD_W-1:0] rx_word1,
  output logic              rx_vld1,
  output logic              rate_ok,
  output logic              rate_hi,
  output logic              pwr_down
);
  localparam int CNT_W = $clog2(2 * WORD_W);

  logic [1:0] rst_sync_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  logic                                 rise, active, ch1_first;
  logic [CNT_W-1:0]                     bit_cnt;
  logic [PCM_NUM_CH-1:0][WORD_W-1:0]    words;
  logic [PCM_NUM_CH-1:0]                vld;

  pcm_frame_ctl #(.WORD_W(WORD_W)) u_frame (
    .clk(clk), .rst_i(rst_i), .fsync(fsync),
    .tx_w0(tx_word0), .tx_w1(tx_word1),
    .rise(rise), .active(active), .bit_cnt(bit_cnt),
    .ch1_first(ch1_first), .tx_data(tx_data), .tx_en(tx_en)
  );

  pcm_rx_deser #(.WORD_W(WORD_W), .NCH(PCM_NUM_CH)) u_rx (
    .clk(clk), .rst_i(rst_i), .rx_data(rx_data),
    .active(active), .bit_cnt(bit_cnt), .ch1_first(ch1_first),
    .words(words), .vld(vld)
  );

  pcm_rate_pd #(.LO_FRAME(LO_FRAME)) u_rate (
    .clk(clk), .rst_i(rst_i), .fsync(fsync), .rise(rise),
    .rate_ok(rate_ok), .rate_hi(rate_hi), .pwr_down(pwr_down)
  );

  assign rx_word0 = words[0];
  assign rx_vld0  = vld[0];
  assign rx_word1 = words[1];
  assign rx_vld1  = vld[1];
endmodule

// File: tb/sim_pcm_tdm_port.sv
module sim_pcm_tdm_port;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic       clk, rst_n, fsync, rx_data;
  logic [7:0] tx_word0, tx_word1;
  logic       tx_data, tx_en, rx_vld0, rx_vld1, rate_ok, rate_hi, pwr_down;
  logic [7:0] rx_word0, rx_word1;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  bit         txq[$];
  logic [8:0] rxq[$];

  pcm_tdm_port u0 (
    .clk(clk), .rst_n(rst_n), .fsync(fsync),
    .tx_word0(tx_word0), .tx_word1(tx_word1),
    .tx_data(tx_data), .tx_en(tx_en), .rx_data(rx_data),
    .rx_word0(rx_word0), .rx_vld0(rx_vld0),
    .rx_word1(rx_word1), .rx_vld1(rx_vld1),
    .rate_ok(rate_ok), .rate_hi(rate_hi), .pwr_down(pwr_down)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      check(1'b0, "watchdog", cycles, WATCHDOG);
      finish_run();
    end
  end

  // monitor: compares outputs against the scoreboard queues
  initial begin
    forever begin
      @(negedge clk);
      if (tx_en) begin
        if (txq.size() == 0) check(1'b0, "R1 unexpected tx bit", 1, 0);
        else begin
          bit e;
          e = txq.pop_front();
          check(tx_data == e, "R2 R3 R4 tx bit", int'(tx_data), int'(e));
        end
      end else if (tx_data) begin
        check(1'b0, "R4 tx_data idle", 1, 0);
      end
      if (rx_vld0 || rx_vld1) begin
        if (rxq.size() == 0) check(1'b0, "R5 unexpected rx strobe", 1, 0);
        else begin
          logic [8:0] e;
          e = rxq.pop_front();
          if (rx_vld0) check({1'b0, rx_word0} == e, "R5 rx word", int'({1'b0, rx_word0}), int'(e));
          else         check({1'b1, rx_word1} == e, "R5 rx word", int'({1'b1, rx_word1}), int'(e));
        end
      end
    end
  end

  // driver: one frame, pushes expected transmit bits and receive words
  task automatic run_frame(input logic [7:0] w0, input logic [7:0] w1,
                           input logic [7:0] r0, input logic [7:0] r1,
                           input int width, input int period);
    logic [15:0] txs, rxs;
    bit first1;
    first1 = (width >= 2);
    txs = first1 ? {w1, w0} : {w0, w1};
    rxs = first1 ? {r1, r0} : {r0, r1};
    for (int i = 15; i >= 0; i--) txq.push_back(txs[i]);
    rxq.push_back({first1, rxs[15:8]});
    rxq.push_back({~first1, rxs[7:0]});
    for (int c = 0; c < period; c++) begin
      @(negedge clk);
      fsync = (c < width);
      if (c == 0) begin
        tx_word0 = w0;
        tx_word1 = w1;
      end
      @(posedge clk);
      #1;
      if (c >= 1 && c <= 16) rx_data = rxs[16 - c];
      else                   rx_data = c[0];
    end
    #1;
    check(txq.size() == 0, "R1 burst length", txq.size(), 0);
    check(rxq.size() == 0, "R5 rx words seen", rxq.size(), 0);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      fsync = 1'b0;
    end
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check({tx_en, tx_data, rx_vld0, rx_vld1, rate_ok, rate_hi, pwr_down} == 7'd0,
          "R9 in reset", int'({tx_en, tx_data, rx_vld0, rx_vld1, rate_ok, rate_hi, pwr_down}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check({tx_en, tx_data, rx_vld0, rx_vld1, rate_ok, rate_hi, pwr_down} == 7'd0,
          "R9 after reset", int'({tx_en, tx_data, rx_vld0, rx_vld1, rate_ok, rate_hi, pwr_down}), 0);
  endtask

  initial begin
    rst_n = 1'b0; fsync = 1'b0; rx_data = 1'b0;
    tx_word0 = 8'h00; tx_word1 = 8'h00;
    do_reset();

    // R2 narrow pulse, R4 MSB first, R5 receive
    run_frame(8'hA5, 8'h3C, 8'h81, 8'h7E, 1, 256);
    check(rate_ok == 1'b0, "R6 one edge unresolved", rate_ok, 0);
    run_frame(8'h01, 8'h80, 8'hC3, 8'h12, 1, 256);
    check(rate_ok && !rate_hi, "R6 low rate", int'({rate_ok, rate_hi}), 2);
    // R3 wide pulses
    run_frame(8'hF0, 8'h0F, 8'h55, 8'hAA, 2, 256);
    run_frame(8'h96, 8'h69, 8'hE1, 8'h1E, 5, 256);
    // R6 lock: a 512 spacing no longer changes the rate
    run_frame(8'h11, 8'hEE, 8'h24, 8'hDB, 1, 512);
    run_frame(8'h5A, 8'hC6, 8'h39, 8'h93, 1, 256);
    check(rate_ok && !rate_hi, "R6 rate locked", int'({rate_ok, rate_hi}), 2);
    // R7 low-rate timeout: 255 quiet samples in frame + 768
    idle(768);
    check(pwr_down == 1'b0, "R7 one short low", pwr_down, 0);
    idle(1);
    check(pwr_down == 1'b1, "R7 timeout low", pwr_down, 1);
    // R8 wake on next frame
    run_frame(8'hB7, 8'h4D, 8'h0F, 8'hF0, 2, 256);
    check(pwr_down == 1'b0, "R8 cleared", pwr_down, 0);

    do_reset();
    // R6 unresolved with 300-cycle spacing, then high rate
    run_frame(8'h12, 8'h34, 8'h56, 8'h78, 1, 300);
    run_frame(8'h9A, 8'hBC, 8'hDE, 8'hF1, 1, 300);
    run_frame(8'h21, 8'h43, 8'h65, 8'h87, 2, 512);
    check(rate_ok == 1'b0, "R6 odd spacing unresolved", rate_ok, 0);
    run_frame(8'hA9, 8'hCB, 8'hED, 8'h1F, 1, 512);
    check(rate_ok && rate_hi, "R6 high rate", int'({rate_ok, rate_hi}), 3);
    // R7 high-rate timeout: 511 quiet samples in frame + 1536
    run_frame(8'h3E, 8'hC1, 8'h7A, 8'h85, 1, 512);
    idle(1536);
    check(pwr_down == 1'b0, "R7 one short high", pwr_down, 0);
    idle(1);
    check(pwr_down == 1'b1, "R7 timeout high", pwr_down, 1);
    run_frame(8'hE4, 8'h1B, 8'h66, 8'h99, 1, 512);
    check(pwr_down == 1'b0, "R8 cleared high", pwr_down, 0);

    finish_run();
  end
endmodule